// File: doc/BRIEF.md
# Write-Protect and Program-Enable Controller

This block is the permission gate for a 256-word by 16-bit serial nonvolatile memory model. The serial front end has already shifted in a command. It hands over the two opcode bits, the eight address-field bits, and the levels of the program-enable and protect-enable pins that were sampled while the command was loaded. The block classifies the command and decides whether it may run. It also keeps the state that governs that decision:

- a write-enable latch,
- a protect boundary with a "nothing protected" flag,
- a one-shot arming flag for protect-register commands,
- a permanent lock bit.

The decision goes to the sequencer one cycle after the command arrives. When a programming cycle must start, `dec_prog` is raised. An abort has `dec_prog` low, so the sequencer reports ready at once and touches no memory.

Commands come in as a valid-only stream: a command is accepted in every cycle in which `cmd_valid` is high, and no ready signal exists. The decision stream comes out the same way, one `dec_valid` pulse per accepted command, and the consumer cannot apply back-pressure. The protect-register value and its cleared flag are plain outputs for read-back.

Top module: `wp_guard`

## Requirements
- R1: While reset is asserted and right after it: writing is disabled, the arming flag and the lock are clear, `prot_clear` is 1, `prot_addr` is all ones, and `dec_valid` is 0.
- R2: Memory erase and write commands (single-word or bulk) are refused while writing is disabled. An enable command sets the write-enable latch only when `pe_pin` is 1; with `pe_pin` at 0 the enable command is refused and has no effect.
- R3: A disable command clears the write-enable latch, so later erases and writes are refused.
- R4: While a boundary is set (`prot_clear` is 0), a single-word erase or write is permitted only when its address is strictly below `prot_addr`. An address equal to or above the boundary is refused.
- R5: A bulk erase or bulk write is permitted only while `prot_clear` is 1, in addition to writing being enabled.
- R6: A protect-clear, protect-write or lock command is permitted only when the command just before it was the arm command. Any other command in between cancels the arming.
- R7: A permitted protect-write loads its address into `prot_addr` and drops `prot_clear`. A permitted protect-clear sets `prot_clear` to 1 and `prot_addr` to all ones.
- R8: After a permitted lock command, protect-clear and protect-write are always refused, and `prot_addr` and `prot_clear` never change again until reset.
- R9: Read and protect-read commands are always permitted, whatever the enable state, and never start a programming cycle.
- R10: A refused command never raises `dec_prog` and changes no state.
- R11: Each command taken with `cmd_valid` produces exactly one `dec_valid` pulse in the next cycle. That pulse carries the kind, the address, and a decision made on the state before the command.
- R12: Decoding, with `pre_pin` low:
  - op 10 is read (kind 1);
  - op 01 is write (kind 2);
  - op 11 is erase (kind 3);
  - op 00 is split by address bits 7:6: 10 is bulk erase (kind 4), 01 is bulk write (kind 5), 11 is enable (kind 6), 00 is disable (kind 7).

  With `pre_pin` high:
  - op 10 is protect-read (kind 8);
  - op 00 with address 11xxxxxx and `pe_pin` high is arm (kind 9);
  - op 11 with address FF is protect-clear (kind 10);
  - op 01 is protect-write (kind 11);
  - op 00 with address 00 is lock (kind 12).

  Every other frame is kind 0 and is refused. `dec_prog` is 1 exactly for a permitted command of kind 2, 3, 4, 5, 10, 11 or 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 2 | Opcode bits of the command |
| cmd_addr | input | 8 | Address field of the command |
| pe_pin | input | 1 | Program-enable pin level sampled during loading |
| pre_pin | input | 1 | Protect-enable pin level sampled during loading |
| dec_valid | output | 1 | Decision for the previous cycle's command |
| dec_kind | output | 4 | Command kind, coded as in R12 |
| dec_addr | output | 8 | Address field of the decided command |
| dec_permit | output | 1 | 1 = command permitted, 0 = aborted |
| dec_prog | output | 1 | Start a programming cycle |
| prot_addr | output | 8 | Current protect boundary |
| prot_clear | output | 1 | 1 = no address is protected |

## Verification
The decision logic is driven through a sequence of commands that walks the guard through each of its states: disabled, enabled, bounded, cleared, and locked.

Writes are placed just below the boundary, on it, and at the top address. This separates a strict comparison from an inclusive one.

Arm commands are followed by a protect command directly, by a read in between, and after the lock. This separates one-shot arming from a sticky flag, and also exposes a lock that does not hold.

Enable attempts with the program-enable pin low and high show whether that pin is consulted. A reset in mid-sequence shows that every piece of state returns to its initial value.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int ADDR_W = 8;
  localparam int OP_W   = 2;

  typedef enum logic [3:0] {
    K_NONE   = 4'd0,
    K_READ   = 4'd1,
    K_WRITE  = 4'd2,
    K_ERASE  = 4'd3,
    K_ERAL   = 4'd4,
    K_WRAL   = 4'd5,
    K_EWEN   = 4'd6,
    K_EWDS   = 4'd7,
    K_PREAD  = 4'd8,
    K_ARM    = 4'd9,
    K_PCLR   = 4'd10,
    K_PWR    = 4'd11,
    K_LOCK   = 4'd12
  } cmd_kind_e;

  function automatic logic is_mem_prog(cmd_kind_e k);
    return (k == K_WRITE) || (k == K_ERASE) || (k == K_ERAL) || (k == K_WRAL);
  endfunction

  function automatic logic is_prot_prog(cmd_kind_e k);
    return (k == K_PCLR) || (k == K_PWR) || (k == K_LOCK);
  endfunction
endpackage

// File: rtl/wp_decode.sv
module wp_decode
  import wp_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic          pe,
  input  logic          pre,
  output cmd_kind_e     kind
);
  logic [1:0] sub;
  assign sub = addr[AW-1 -: 2];

  always_comb begin
    kind = K_NONE;
    unique case (op)
      2'b10: kind = pre ? K_PREAD : K_READ;
      2'b01: kind = pre ? K_PWR : K_WRITE;
      2'b11: kind = pre ? ((&addr) ? K_PCLR : K_NONE) : K_ERASE;
      default: begin
        unique case (sub)
          2'b11:   kind = pre ? (pe ? K_ARM : K_NONE) : K_EWEN;
          2'b00:   kind = pre ? ((addr == '0) ? K_LOCK : K_NONE) : K_EWDS;
          2'b10:   kind = pre ? K_NONE : K_ERAL;
          default: kind = pre ? K_NONE : K_WRAL;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/wp_enable.sv
module wp_enable
  import wp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  input  cmd_kind_e kind,
  input  logic      pe,
  output logic      wen_q,
  output logic      arm_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wen_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (step) begin
      if (kind == K_EWEN && pe) wen_q <= 1'b1;
      else if (kind == K_EWDS)  wen_q <= 1'b0;
      arm_q <= (kind == K_ARM);
    end
  end
endmodule

// File: rtl/wp_protect.sv
module wp_protect
  import wp_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  cmd_kind_e     kind,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] bound_q,
  output logic          clr_q,
  output logic          lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bound_q <= '1;
      clr_q   <= 1'b1;
      lock_q  <= 1'b0;
    end else if (go) begin
      unique case (kind)
        K_PCLR: begin
          bound_q <= '1;
          clr_q   <= 1'b1;
        end
        K_PWR: begin
          bound_q <= addr;
          clr_q   <= 1'b0;
        end
        K_LOCK:  lock_q <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic          pe_pin,
  input  logic          pre_pin,
  output logic          dec_valid,
  output logic [3:0]    dec_kind,
  output logic [AW-1:0] dec_addr,
  output logic          dec_permit,
  output logic          dec_prog,
  output logic [AW-1:0] prot_addr,
  output logic          prot_clear
);
  cmd_kind_e     kind;
  logic          wen_q, arm_q, lock_q, clr_q;
  logic [AW-1:0] bound_q;
  logic          permit, prog, prot_go;

  wp_decode #(.AW(AW)) u_dec (
    .op(cmd_op), .addr(cmd_addr), .pe(pe_pin), .pre(pre_pin), .kind(kind)
  );

  wp_enable u_en (
    .clk(clk), .rst_n(rst_n), .step(cmd_valid), .kind(kind), .pe(pe_pin),
    .wen_q(wen_q), .arm_q(arm_q)
  );

  wp_protect #(.AW(AW)) u_prot (
    .clk(clk), .rst_n(rst_n), .go(prot_go), .kind(kind), .addr(cmd_addr),
    .bound_q(bound_q), .clr_q(clr_q), .lock_q(lock_q)
  );

  always_comb begin
    unique case (kind)
      K_READ, K_PREAD, K_EWDS, K_ARM: permit = 1'b1;
      K_EWEN:                         permit = pe_pin;
      K_WRITE, K_ERASE:               permit = wen_q && (clr_q || (cmd_addr < bound_q));
      K_ERAL, K_WRAL:                 permit = wen_q && clr_q;
      K_PCLR, K_PWR, K_LOCK:          permit = arm_q && !lock_q;
      default:                        permit = 1'b0;
    endcase
  end

  assign prog    = permit && (is_mem_prog(kind) || is_prot_prog(kind));
  assign prot_go = cmd_valid && permit && is_prot_prog(kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_kind   <= 4'd0;
      dec_addr   <= '0;
      dec_permit <= 1'b0;
      dec_prog   <= 1'b0;
    end else begin
      dec_valid <= cmd_valid;
      if (cmd_valid) begin
        dec_kind   <= kind;
        dec_addr   <= cmd_addr;
        dec_permit <= permit;
        dec_prog   <= prog;
      end
    end
  end

  assign prot_addr  = bound_q;
  assign prot_clear = clr_q;
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk
  import wp_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          dec_valid,
  input logic [3:0]    dec_kind,
  input logic [AW-1:0] dec_addr,
  input logic          dec_permit,
  input logic          dec_prog,
  input logic [AW-1:0] prot_addr,
  input logic          prot_clear,
  input logic          wen_q,
  input logic          arm_q,
  input logic          lock_q
);
  logic k_memw, k_bulk, k_prot, k_read;
  assign k_memw = (dec_kind == K_WRITE) || (dec_kind == K_ERASE);
  assign k_bulk = (dec_kind == K_ERAL) || (dec_kind == K_WRAL);
  assign k_prot = (dec_kind == K_PCLR) || (dec_kind == K_PWR) || (dec_kind == K_LOCK);
  assign k_read = (dec_kind == K_READ) || (dec_kind == K_PREAD);

  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> dec_valid);
  assert_no_orphan_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(cmd_valid));
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_permit) |-> !dec_prog);
  assert_need_wen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_permit && (k_memw || k_bulk)) |-> $past(wen_q));
  assert_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_permit && k_memw) |-> ($past(prot_clear) || (dec_addr < $past(prot_addr))));
  assert_bulk_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_permit && k_bulk) |-> $past(prot_clear));
  assert_arm_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_permit && k_prot) |-> $past(arm_q));
  assert_lock_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> (lock_q && $stable(prot_addr) && $stable(prot_clear)));
  assert_read_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && k_read) |-> (dec_permit && !dec_prog));
endmodule

bind wp_guard wp_guard_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .dec_valid(dec_valid),
  .dec_kind(dec_kind), .dec_addr(dec_addr), .dec_permit(dec_permit),
  .dec_prog(dec_prog), .prot_addr(prot_addr), .prot_clear(prot_clear),
  .wen_q(wen_q), .arm_q(arm_q), .lock_q(lock_q)
);

// File: tb/tb_wp_guard.sv
`timescale 1ns/1ps
module tb_wp_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_addr = 8'h00;
  logic       pe_pin = 1'b0;
  logic       pre_pin = 1'b0;
  logic       dec_valid, dec_permit, dec_prog, prot_clear;
  logic [3:0] dec_kind;
  logic [7:0] dec_addr, prot_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  wp_guard dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .pe_pin(pe_pin), .pre_pin(pre_pin),
    .dec_valid(dec_valid), .dec_kind(dec_kind), .dec_addr(dec_addr),
    .dec_permit(dec_permit), .dec_prog(dec_prog), .prot_addr(prot_addr),
    .prot_clear(prot_clear)
  );

  typedef struct packed {
    logic       pre;
    logic       pe;
    logic [1:0] op;
    logic [7:0] addr;
    logic [3:0] kind;
    logic       permit;
    logic       prog;
    logic [7:0] paddr;
    logic       pclr;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,2'b01,8'h10, 4'd2, 1'b0,1'b0, 8'hFF,1'b1, 4'd2 },  // R2 write while disabled
    '{1'b0,1'b0,2'b00,8'hC0, 4'd6, 1'b0,1'b0, 8'hFF,1'b1, 4'd2 },  // R2 enable, pe low
    '{1'b0,1'b1,2'b01,8'h10, 4'd2, 1'b0,1'b0, 8'hFF,1'b1, 4'd2 },  // R2 still disabled
    '{1'b0,1'b1,2'b00,8'hC0, 4'd6, 1'b1,1'b0, 8'hFF,1'b1, 4'd2 },  // R2 enable, pe high
    '{1'b0,1'b1,2'b01,8'h10, 4'd2, 1'b1,1'b1, 8'hFF,1'b1, 4'd2 },  // R2 write now ok
    '{1'b0,1'b1,2'b00,8'h80, 4'd4, 1'b1,1'b1, 8'hFF,1'b1, 4'd5 },  // R5 bulk erase, cleared
    '{1'b1,1'b1,2'b01,8'h80, 4'd11,1'b0,1'b0, 8'hFF,1'b1, 4'd6 },  // R6 protect-write unarmed
    '{1'b1,1'b1,2'b00,8'hC0, 4'd9, 1'b1,1'b0, 8'hFF,1'b1, 4'd6 },  // R6 arm
    '{1'b1,1'b1,2'b01,8'h80, 4'd11,1'b1,1'b1, 8'h80,1'b0, 4'd7 },  // R7 load boundary 80
    '{1'b0,1'b1,2'b01,8'h7F, 4'd2, 1'b1,1'b1, 8'h80,1'b0, 4'd4 },  // R4 just below
    '{1'b0,1'b1,2'b01,8'h80, 4'd2, 1'b0,1'b0, 8'h80,1'b0, 4'd4 },  // R4 on boundary
    '{1'b0,1'b1,2'b11,8'hFF, 4'd3, 1'b0,1'b0, 8'h80,1'b0, 4'd4 },  // R4 erase top
    '{1'b0,1'b1,2'b00,8'h40, 4'd5, 1'b0,1'b0, 8'h80,1'b0, 4'd5 },  // R5 bulk write bounded
    '{1'b0,1'b0,2'b10,8'h90, 4'd1, 1'b1,1'b0, 8'h80,1'b0, 4'd9 },  // R9 read
    '{1'b1,1'b0,2'b10,8'h00, 4'd8, 1'b1,1'b0, 8'h80,1'b0, 4'd9 },  // R9 protect-read
    '{1'b1,1'b1,2'b00,8'hC0, 4'd9, 1'b1,1'b0, 8'h80,1'b0, 4'd6 },  // R6 arm
    '{1'b0,1'b1,2'b10,8'h00, 4'd1, 1'b1,1'b0, 8'h80,1'b0, 4'd6 },  // R6 read between
    '{1'b1,1'b1,2'b11,8'hFF, 4'd10,1'b0,1'b0, 8'h80,1'b0, 4'd6 },  // R6 clear rejected
    '{1'b1,1'b1,2'b00,8'hC0, 4'd9, 1'b1,1'b0, 8'h80,1'b0, 4'd6 },  // R6 arm
    '{1'b1,1'b1,2'b11,8'hFF, 4'd10,1'b1,1'b1, 8'hFF,1'b1, 4'd7 },  // R7 clear
    '{1'b0,1'b1,2'b00,8'h40, 4'd5, 1'b1,1'b1, 8'hFF,1'b1, 4'd5 },  // R5 bulk write cleared
    '{1'b1,1'b1,2'b00,8'hC0, 4'd9, 1'b1,1'b0, 8'hFF,1'b1, 4'd6 },  // R6 arm
    '{1'b1,1'b1,2'b01,8'h40, 4'd11,1'b1,1'b1, 8'h40,1'b0, 4'd7 },  // R7 boundary 40
    '{1'b0,1'b1,2'b00,8'h00, 4'd7, 1'b1,1'b0, 8'h40,1'b0, 4'd3 },  // R3 disable
    '{1'b0,1'b1,2'b01,8'h10, 4'd2, 1'b0,1'b0, 8'h40,1'b0, 4'd3 },  // R3 write refused
    '{1'b1,1'b1,2'b00,8'hC0, 4'd9, 1'b1,1'b0, 8'h40,1'b0, 4'd8 },  // R8 arm
    '{1'b1,1'b1,2'b00,8'h00, 4'd12,1'b1,1'b1, 8'h40,1'b0, 4'd8 },  // R8 lock
    '{1'b1,1'b1,2'b00,8'hC0, 4'd9, 1'b1,1'b0, 8'h40,1'b0, 4'd8 },  // R8 arm
    '{1'b1,1'b1,2'b11,8'hFF, 4'd10,1'b0,1'b0, 8'h40,1'b0, 4'd8 },  // R8 clear after lock
    '{1'b1,1'b1,2'b00,8'hC0, 4'd9, 1'b1,1'b0, 8'h40,1'b0, 4'd8 },  // R8 arm
    '{1'b1,1'b1,2'b01,8'h20, 4'd11,1'b0,1'b0, 8'h40,1'b0, 4'd8 },  // R8 write after lock
    '{1'b1,1'b0,2'b00,8'hC0, 4'd0, 1'b0,1'b0, 8'h40,1'b0, 4'd12}   // R12 arm frame, pe low
  };

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic pre, input logic pe, input logic [1:0] op, input logic [7:0] a);
    @(negedge clk);
    pre_pin = pre; pe_pin = pe; cmd_op = op; cmd_addr = a; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    string r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", dec_valid, 0, "dec_valid in reset");
    chk("R1", prot_clear, 1, "prot_clear in reset");
    chk("R1", prot_addr, 8'hFF, "prot_addr in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", dec_valid, 0, "dec_valid idle");

    for (int i = 0; i < NV; i++) begin
      r = $sformatf("R%0d", VEC[i].req);
      send(VEC[i].pre, VEC[i].pe, VEC[i].op, VEC[i].addr);
      chk("R11", dec_valid, 1, $sformatf("dec_valid vec %0d", i));
      chk("R12", dec_kind, VEC[i].kind, $sformatf("kind vec %0d", i));
      chk("R11", dec_addr, VEC[i].addr, $sformatf("addr vec %0d", i));
      chk(r, dec_permit, VEC[i].permit, $sformatf("permit vec %0d", i));
      chk("R10", dec_prog, VEC[i].prog, $sformatf("prog vec %0d", i));
      chk(r, prot_addr, VEC[i].paddr, $sformatf("prot_addr vec %0d", i));
      chk(r, prot_clear, VEC[i].pclr, $sformatf("prot_clear vec %0d", i));
    end

    @(negedge clk);
    chk("R11", dec_valid, 0, "single pulse");

    // R1 reset mid-sequence returns all state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", prot_addr, 8'hFF, "prot_addr after reset");
    chk("R1", prot_clear, 1, "prot_clear after reset");
    send(1'b0, 1'b1, 2'b01, 8'h05);
    chk("R1", dec_permit, 0, "write disabled after reset");
    send(1'b1, 1'b1, 2'b00, 8'hFF);
    send(1'b1, 1'b1, 2'b01, 8'h33);
    chk("R1", dec_permit, 1, "lock gone after reset");
    chk("R7", prot_addr, 8'h33, "boundary after reset");

    // R10 refused protect command after arm: state unchanged, no prog
    send(1'b1, 1'b1, 2'b11, 8'hFF);
    chk("R10", dec_permit, 0, "unarmed clear");
    chk("R10", dec_prog, 0, "unarmed clear prog");
    chk("R10", prot_addr, 8'h33, "unarmed clear state");

    // R9 back-to-back commands: each gives its own decision
    @(negedge clk);
    pre_pin = 1'b0; pe_pin = 1'b0; cmd_op = 2'b10; cmd_addr = 8'h01; cmd_valid = 1'b1;
    @(negedge clk);
    chk("R9", dec_kind, 1, "b2b first kind");
    cmd_op = 2'b01; cmd_addr = 8'h02;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11", dec_valid, 1, "b2b second valid");
    chk("R2", dec_permit, 0, "b2b write disabled");
    chk("R11", dec_addr, 8'h02, "b2b second addr");

    finish_run();
  end
endmodule